// File: doc/BRIEF.md
# Self-Learning Exact-Match Table with Idle Aging

This block is a small fully associative lookup table keyed by an exact value. A data-path client presents a key and receives, one cycle later, a hit flag, the index of the matching entry and its action data. When a lookup misses, the client may ask the table to learn that key together with its own action data and an optional idle time-to-live. The table places the new entry in the lowest free slot and answers with a success or failure flag. Software is not involved in learning. A separate control-plane port can still write or delete any entry by index, and that includes entries the data path learned.

Each entry has an idle counter. The counter advances on a prescaled tick input and is cleared whenever the entry is hit. When table aging is set to notify, a background scanner visits one entry per cycle. It emits a notification carrying the index and key of any entry whose idle count has reached its nonzero TTL. The notification is presented over a valid/ready handshake. It is raised only once per expiry, and the entry becomes eligible again only after it is hit or rewritten. The miss case has no entry and is never aged.

Top module: `learn_table`

## Requirements
- R1: A lookup presented with `lookup_valid_i` returns, on the next cycle, `lookup_done_o`=1 and `hit_o`=1 with `hit_idx_o` and `hit_data_o` of the valid entry whose key equals the lookup key exactly; with no such entry `hit_o`=0.
- R2: A learn request while `learn_en_i`=0 reports `learn_ok_o`=0 and leaves the table unchanged.
- R3: An accepted learn request stores the requested key, data and TTL in the lowest-numbered free entry. One cycle after the request it reports `learn_done_o`=1, `learn_ok_o`=1 and that index on `learn_idx_o`.
- R4: A learn request fails (`learn_ok_o`=0) when no entry is free or when the key is already present.
- R5: A lookup presented in the cycle right after an accepted learn request hits the newly learned entry.
- R6: A control-plane operation with `cp_op_i`=0 writes key, data and TTL into entry `cp_idx_i` and makes it valid, overwriting whatever was there, learned or not. With `cp_op_i`=1 the operation invalidates the entry.
- R7: When a control-plane operation and a learn request occur in the same cycle, the control-plane operation takes effect and the learn request reports failure.
- R8: Each entry's idle counter (saturating, TTL width) increments on each `tick_i` pulse and is cleared by a hit. With `aging_mode_i`=1 (notify), an entry whose TTL is nonzero and whose idle count is at least its TTL produces a notification with its index and key. The notification stays stable on the outputs until `notif_ready_i` is seen.
- R9: An expired entry raises exactly one notification; it raises another only after a hit (or rewrite) and a fresh expiry.
- R10: An entry with TTL 0 never raises a notification.
- R11: With `aging_mode_i`=0 (no timeout) no notification is raised. Switching to notify then reports entries already past their TTL.
- R12: After reset all entries are invalid and `lookup_done_o`, `learn_done_o` and `notif_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| learn_en_i | input | 1 | Table-level learn-on-miss enable |
| aging_mode_i | input | 1 | 0 = no timeout, 1 = notify |
| tick_i | input | 1 | Prescaled aging tick, one-cycle pulse |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_key_i | input | KEY_W | Lookup key |
| lookup_done_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | Lookup matched an entry |
| hit_idx_o | output | IDX_W | Index of matching entry |
| hit_data_o | output | DATA_W | Action data of matching entry |
| learn_valid_i | input | 1 | Learn request |
| learn_key_i | input | KEY_W | Key to learn |
| learn_data_i | input | DATA_W | Action data to store |
| learn_ttl_i | input | TTL_W | Idle TTL in ticks, 0 = never ages |
| learn_done_o | output | 1 | Learn result valid |
| learn_ok_o | output | 1 | 1 = inserted, 0 = failed |
| learn_idx_o | output | IDX_W | Index used by an accepted learn |
| cp_valid_i | input | 1 | Control-plane operation strobe |
| cp_op_i | input | 1 | 0 = write, 1 = delete |
| cp_idx_i | input | IDX_W | Target entry index |
| cp_key_i | input | KEY_W | Key for write |
| cp_data_i | input | DATA_W | Action data for write |
| cp_ttl_i | input | TTL_W | TTL for write |
| notif_valid_o | output | 1 | Expiry notification pending |
| notif_ready_i | input | 1 | Consumer accepts notification |
| notif_idx_o | output | IDX_W | Index of expired entry |
| notif_key_o | output | KEY_W | Key of expired entry |

## Verification
The bench issues a lookup in the cycle right after a learn. A design that commits the new entry late would miss there. It also raises a learn request together with a control-plane write, where a design that lets both write the store would lose one of them, and it fills all sixteen slots to show the seventeenth learn fails rather than overwriting an entry. On the aging side it holds ready low to catch a notification that changes or drops before acceptance. It keeps ticking after an expiry to expose repeated notifications, and it re-arms an entry by hitting it. TTL-0 entries and the no-timeout mode must stay silent, which exposes a design that compares the idle count without qualifying it.

// File: rtl/learn_table_pkg.sv
package learn_table_pkg;
  typedef enum logic {CP_WRITE = 1'b0, CP_DELETE = 1'b1} cp_op_e;
  typedef enum logic {AGE_OFF = 1'b0, AGE_NOTIFY = 1'b1} age_mode_e;
endpackage

// File: rtl/lt_store.sv
module lt_store #(
  parameter int N      = 16,
  parameter int KEY_W  = 16,
  parameter int DATA_W = 16,
  parameter int TTL_W  = 8,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [KEY_W-1:0]            wr_key_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic [TTL_W-1:0]            wr_ttl_i,
  input  logic                        del_en_i,
  input  logic [IDX_W-1:0]            del_idx_i,
  input  logic [KEY_W-1:0]            lk_key_i,
  input  logic [KEY_W-1:0]            ln_key_i,
  output logic [N-1:0]                valid_o,
  output logic [N-1:0][KEY_W-1:0]     key_o,
  output logic [N-1:0][DATA_W-1:0]    data_o,
  output logic [N-1:0][TTL_W-1:0]     ttl_o,
  output logic [N-1:0]                lk_match_o,
  output logic [N-1:0]                ln_match_o,
  output logic                        free_any_o,
  output logic [IDX_W-1:0]            free_idx_o
);
  logic [N-1:0] valid_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        key_o[i]   <= '0;
        data_o[i]  <= '0;
        ttl_o[i]   <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(i)) begin
        valid_q[i] <= 1'b1;
        key_o[i]   <= wr_key_i;
        data_o[i]  <= wr_data_i;
        ttl_o[i]   <= wr_ttl_i;
      end else if (del_en_i && del_idx_i == IDX_W'(i)) begin
        valid_q[i] <= 1'b0;
      end
    end
    assign lk_match_o[i] = valid_q[i] && key_o[i] == lk_key_i;
    assign ln_match_o[i] = valid_q[i] && key_o[i] == ln_key_i;
  end

  assign valid_o    = valid_q;
  assign free_any_o = ~&valid_q;

  // lowest free slot
  always_comb begin
    free_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx_o = IDX_W'(i);
    end
  end

  p_delete_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    del_en_i && !wr_en_i |=> !valid_q[$past(del_idx_i)]);
  p_write_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(wr_idx_i)] && key_o[$past(wr_idx_i)] == $past(wr_key_i));
endmodule

// File: rtl/lt_ager.sv
module lt_ager #(
  parameter int N     = 16,
  parameter int TTL_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic                     mode_i,
  input  logic [N-1:0]             hit_i,
  input  logic [N-1:0]             clear_i,
  input  logic [N-1:0]             take_i,
  input  logic [N-1:0]             valid_i,
  input  logic [N-1:0][TTL_W-1:0]  ttl_i,
  output logic [N-1:0]             expired_o
);
  localparam logic [TTL_W-1:0] IDLE_MAX = '1;

  logic [N-1:0][TTL_W-1:0] idle_q;
  logic [N-1:0]            told_q;

  for (genvar i = 0; i < N; i++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        idle_q[i] <= '0;
        told_q[i] <= 1'b0;
      end else if (clear_i[i] || hit_i[i]) begin
        idle_q[i] <= '0;
        told_q[i] <= 1'b0;
      end else begin
        if (tick_i && idle_q[i] != IDLE_MAX) idle_q[i] <= idle_q[i] + 1'b1;
        if (take_i[i]) told_q[i] <= 1'b1;
      end
    end

    assign expired_o[i] = mode_i && valid_i[i] && (ttl_i[i] != '0) &&
                          (idle_q[i] >= ttl_i[i]) && !told_q[i];

    p_hit_resets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[i] |=> idle_q[i] == '0);
    p_once_per_expiry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i[i] |=> !expired_o[i]);
  end
endmodule

// File: rtl/lt_scanner.sv
module lt_scanner #(
  parameter int N     = 16,
  parameter int KEY_W = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N-1:0]             expired_i,
  input  logic [N-1:0][KEY_W-1:0]  key_i,
  output logic [N-1:0]             take_o,
  output logic                     notif_valid_o,
  input  logic                     notif_ready_i,
  output logic [IDX_W-1:0]         notif_idx_o,
  output logic [KEY_W-1:0]         notif_key_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] ptr_q;
  logic             nv_q;
  logic             load;

  assign load = !nv_q && expired_i[ptr_q];

  always_comb begin
    take_o = '0;
    if (load) take_o[ptr_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      nv_q        <= 1'b0;
      notif_idx_o <= '0;
      notif_key_o <= '0;
    end else begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      if (load) begin
        nv_q        <= 1'b1;
        notif_idx_o <= ptr_q;
        notif_key_o <= key_i[ptr_q];
      end else if (nv_q && notif_ready_i) begin
        nv_q <= 1'b0;
      end
    end
  end

  assign notif_valid_o = nv_q;

  p_hold_until_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_q && !notif_ready_i |=> nv_q && $stable(notif_idx_o) && $stable(notif_key_o));
  p_take_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take_o));
endmodule

// File: rtl/learn_table.sv
module learn_table
  import learn_table_pkg::*;
#(
  parameter int N      = 16,
  parameter int KEY_W  = 16,
  parameter int DATA_W = 16,
  parameter int TTL_W  = 8,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              learn_en_i,
  input  logic              aging_mode_i,
  input  logic              tick_i,
  input  logic              lookup_valid_i,
  input  logic [KEY_W-1:0]  lookup_key_i,
  output logic              lookup_done_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [DATA_W-1:0] hit_data_o,
  input  logic              learn_valid_i,
  input  logic [KEY_W-1:0]  learn_key_i,
  input  logic [DATA_W-1:0] learn_data_i,
  input  logic [TTL_W-1:0]  learn_ttl_i,
  output logic              learn_done_o,
  output logic              learn_ok_o,
  output logic [IDX_W-1:0]  learn_idx_o,
  input  logic              cp_valid_i,
  input  logic              cp_op_i,
  input  logic [IDX_W-1:0]  cp_idx_i,
  input  logic [KEY_W-1:0]  cp_key_i,
  input  logic [DATA_W-1:0] cp_data_i,
  input  logic [TTL_W-1:0]  cp_ttl_i,
  output logic              notif_valid_o,
  input  logic              notif_ready_i,
  output logic [IDX_W-1:0]  notif_idx_o,
  output logic [KEY_W-1:0]  notif_key_o
);
  logic [N-1:0]              valid, lk_match, ln_match, hit_vec, clear_vec, take, expired;
  logic [N-1:0][KEY_W-1:0]   keys;
  logic [N-1:0][DATA_W-1:0]  datas;
  logic [N-1:0][TTL_W-1:0]   ttls;
  logic                      free_any;
  logic [IDX_W-1:0]          free_idx;
  logic                      cp_wr, cp_del, learn_acc, wr_en;
  logic [IDX_W-1:0]          wr_idx;
  logic [KEY_W-1:0]          wr_key;
  logic [DATA_W-1:0]         wr_data;
  logic [TTL_W-1:0]          wr_ttl;
  logic                      lk_any;
  logic [IDX_W-1:0]          lk_idx;

  assign cp_wr  = cp_valid_i && cp_op_e'(cp_op_i) == CP_WRITE;
  assign cp_del = cp_valid_i && cp_op_e'(cp_op_i) == CP_DELETE;
  // control plane owns the store port in any cycle it is active
  assign learn_acc = learn_valid_i && learn_en_i && !cp_valid_i && free_any && !(|ln_match);

  assign wr_en   = cp_wr || learn_acc;
  assign wr_idx  = cp_wr ? cp_idx_i  : free_idx;
  assign wr_key  = cp_wr ? cp_key_i  : learn_key_i;
  assign wr_data = cp_wr ? cp_data_i : learn_data_i;
  assign wr_ttl  = cp_wr ? cp_ttl_i  : learn_ttl_i;

  lt_store #(.N(N), .KEY_W(KEY_W), .DATA_W(DATA_W), .TTL_W(TTL_W), .IDX_W(IDX_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_key_i(wr_key), .wr_data_i(wr_data), .wr_ttl_i(wr_ttl),
    .del_en_i(cp_del), .del_idx_i(cp_idx_i),
    .lk_key_i(lookup_key_i), .ln_key_i(learn_key_i),
    .valid_o(valid), .key_o(keys), .data_o(datas), .ttl_o(ttls),
    .lk_match_o(lk_match), .ln_match_o(ln_match),
    .free_any_o(free_any), .free_idx_o(free_idx)
  );

  always_comb begin
    lk_any = 1'b0;
    lk_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lk_match[i]) begin
        lk_any = 1'b1;
        lk_idx = IDX_W'(i);
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_vec
    assign hit_vec[i]   = lookup_valid_i && lk_match[i];
    assign clear_vec[i] = (wr_en && wr_idx == IDX_W'(i)) || (cp_del && cp_idx_i == IDX_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lookup_done_o <= 1'b0;
      hit_o         <= 1'b0;
      hit_idx_o     <= '0;
      hit_data_o    <= '0;
      learn_done_o  <= 1'b0;
      learn_ok_o    <= 1'b0;
      learn_idx_o   <= '0;
    end else begin
      lookup_done_o <= lookup_valid_i;
      hit_o         <= lookup_valid_i && lk_any;
      hit_idx_o     <= lk_idx;
      hit_data_o    <= datas[lk_idx];
      learn_done_o  <= learn_valid_i;
      learn_ok_o    <= learn_acc;
      learn_idx_o   <= free_idx;
    end
  end

  lt_ager #(.N(N), .TTL_W(TTL_W)) u_ager (
    .clk_i, .rst_ni, .tick_i, .mode_i(age_mode_e'(aging_mode_i) == AGE_NOTIFY),
    .hit_i(hit_vec), .clear_i(clear_vec), .take_i(take),
    .valid_i(valid), .ttl_i(ttls), .expired_o(expired)
  );

  lt_scanner #(.N(N), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_scan (
    .clk_i, .rst_ni, .expired_i(expired), .key_i(keys), .take_o(take),
    .notif_valid_o, .notif_ready_i, .notif_idx_o, .notif_key_o
  );

  p_learn_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    learn_ok_o |-> $past(learn_en_i));
  p_cp_beats_learn_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    learn_valid_i && cp_valid_i |=> learn_done_o && !learn_ok_o);
  p_mode_gates_notif_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(notif_valid_o) |-> $past(aging_mode_i));
  p_learn_hits_next_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    learn_acc && !cp_valid_i ##1 lookup_valid_i && lookup_key_i == $past(learn_key_i) |=> hit_o);
endmodule

// File: tb/sim_learn_table.sv
`timescale 1ns/1ps
module sim_learn_table;
  localparam int N = 16, KW = 16, DW = 16, TW = 8, IW = 4;

  logic clk = 0, rst_n = 0;
  logic learn_en = 0, mode = 0, tick = 0;
  logic lk_v = 0; logic [KW-1:0] lk_key = 0;
  logic lk_done, hit; logic [IW-1:0] hit_idx; logic [DW-1:0] hit_data;
  logic ln_v = 0; logic [KW-1:0] ln_key = 0; logic [DW-1:0] ln_data = 0; logic [TW-1:0] ln_ttl = 0;
  logic ln_done, ln_ok; logic [IW-1:0] ln_idx;
  logic cp_v = 0, cp_op = 0; logic [IW-1:0] cp_idx = 0;
  logic [KW-1:0] cp_key = 0; logic [DW-1:0] cp_data = 0; logic [TW-1:0] cp_ttl = 0;
  logic nv, nrdy = 0; logic [IW-1:0] nidx; logic [KW-1:0] nkey;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  learn_table u0 (
    .clk_i(clk), .rst_ni(rst_n), .learn_en_i(learn_en), .aging_mode_i(mode), .tick_i(tick),
    .lookup_valid_i(lk_v), .lookup_key_i(lk_key), .lookup_done_o(lk_done), .hit_o(hit),
    .hit_idx_o(hit_idx), .hit_data_o(hit_data),
    .learn_valid_i(ln_v), .learn_key_i(ln_key), .learn_data_i(ln_data), .learn_ttl_i(ln_ttl),
    .learn_done_o(ln_done), .learn_ok_o(ln_ok), .learn_idx_o(ln_idx),
    .cp_valid_i(cp_v), .cp_op_i(cp_op), .cp_idx_i(cp_idx), .cp_key_i(cp_key),
    .cp_data_i(cp_data), .cp_ttl_i(cp_ttl),
    .notif_valid_o(nv), .notif_ready_i(nrdy), .notif_idx_o(nidx), .notif_key_o(nkey)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input string req, input logic [KW-1:0] k, input bit exp_hit,
                        input int exp_idx, input int exp_data);
    @(negedge clk); lk_v = 1; lk_key = k;
    @(negedge clk); lk_v = 0;
    chk(req, "hit", int'(hit), int'(exp_hit));
    if (exp_hit) begin
      chk(req, "hit_idx", int'(hit_idx), exp_idx);
      chk(req, "hit_data", int'(hit_data), exp_data);
    end
  endtask

  task automatic learn(input string req, input logic [KW-1:0] k, input logic [DW-1:0] d,
                       input bit exp_ok, input int exp_idx);
    @(negedge clk); ln_v = 1; ln_key = k; ln_data = d; ln_ttl = 0;
    @(negedge clk); ln_v = 0;
    chk(req, "learn_done", int'(ln_done), 1);
    chk(req, "learn_ok", int'(ln_ok), int'(exp_ok));
    if (exp_ok) chk(req, "learn_idx", int'(ln_idx), exp_idx);
  endtask

  task automatic cp(input bit op, input int idx, input logic [KW-1:0] k,
                    input logic [DW-1:0] d, input logic [TW-1:0] t);
    @(negedge clk); cp_v = 1; cp_op = op; cp_idx = IW'(idx); cp_key = k; cp_data = d; cp_ttl = t;
    @(negedge clk); cp_v = 0;
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic wait_notif(output bit seen);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (nv) begin seen = 1; break; end
    end
  endtask

  task automatic drain;
    @(negedge clk); nrdy = 1;
    @(negedge clk); nrdy = 0;
  endtask

  task automatic t_reset;
    chk("R12", "lookup_done", int'(lk_done), 0);
    chk("R12", "learn_done", int'(ln_done), 0);
    chk("R12", "notif_valid", int'(nv), 0);
    lookup("R12", 16'h0000, 0, 0, 0);
  endtask

  task automatic t_cp_lookup;
    cp(0, 3, 16'h1234, 16'hAAAA, 0);
    lookup("R1", 16'h1234, 1, 3, 16'hAAAA);
    lookup("R1", 16'h1235, 0, 0, 0);
  endtask

  task automatic t_learn_disabled;
    learn_en = 0;
    learn("R2", 16'h5555, 16'hBEEF, 0, 0);
    lookup("R2", 16'h5555, 0, 0, 0);
  endtask

  task automatic t_learn_next_hit;
    learn_en = 1;
    @(negedge clk); ln_v = 1; ln_key = 16'h5555; ln_data = 16'hBEEF; ln_ttl = 0;
    @(negedge clk); ln_v = 0; lk_v = 1; lk_key = 16'h5555;
    chk("R3", "learn_ok", int'(ln_ok), 1);
    chk("R3", "learn_idx lowest free", int'(ln_idx), 0);
    @(negedge clk); lk_v = 0;
    chk("R5", "next-cycle hit", int'(hit), 1);
    chk("R5", "hit_idx", int'(hit_idx), 0);
    chk("R3", "hit_data", int'(hit_data), 16'hBEEF);
    learn("R4", 16'h5555, 16'h0101, 0, 0);
  endtask

  task automatic t_collision;
    @(negedge clk); ln_v = 1; ln_key = 16'h6060; ln_data = 16'h0606;
    cp_v = 1; cp_op = 0; cp_idx = 9; cp_key = 16'h4444; cp_data = 16'h4040; cp_ttl = 0;
    @(negedge clk); ln_v = 0; cp_v = 0;
    chk("R7", "learn_ok under cp", int'(ln_ok), 0);
    lookup("R7", 16'h4444, 1, 9, 16'h4040);
    lookup("R7", 16'h6060, 0, 0, 0);
  endtask

  task automatic t_cp_edit_learned;
    cp(1, 0, 0, 0, 0);
    lookup("R6", 16'h5555, 0, 0, 0);
    learn("R3", 16'h6666, 16'h0066, 1, 0);
    cp(0, 0, 16'h7777, 16'h1111, 0);
    lookup("R6", 16'h6666, 0, 0, 0);
    lookup("R6", 16'h7777, 1, 0, 16'h1111);
  endtask

  task automatic t_fill;
    for (int i = 0; i < N; i++) cp(1, i, 0, 0, 0);
    for (int i = 0; i < N; i++) learn("R3", KW'(16'h0100 + i), DW'(i), 1, i);
    learn("R4", 16'h0999, 16'h9999, 0, 0);
    lookup("R4", 16'h0999, 0, 0, 0);
    lookup("R3", 16'h010F, 1, 15, 15);
    for (int i = 0; i < N; i++) cp(1, i, 0, 0, 0);
  endtask

  task automatic t_aging;
    bit seen;
    mode = 1;
    cp(0, 2, 16'h0A0A, 16'h00AA, 3);
    cp(0, 4, 16'h0B0B, 16'h00BB, 0);
    pulse_tick(2);
    wait_notif(seen);
    chk("R8", "no notif before ttl", int'(seen), 0);
    pulse_tick(1);
    wait_notif(seen);
    chk("R8", "notif at ttl", int'(seen), 1);
    chk("R8", "notif_idx", int'(nidx), 2);
    chk("R8", "notif_key", int'(nkey), 16'h0A0A);
    repeat (5) @(negedge clk);
    chk("R8", "held without ready", int'(nv), 1);
    chk("R8", "idx stable", int'(nidx), 2);
    drain;
    chk("R8", "dropped after ready", int'(nv), 0);
    pulse_tick(5);
    wait_notif(seen);
    chk("R9", "no repeat notif", int'(seen), 0);
    chk("R10", "ttl0 entry silent", int'(seen), 0);
    lookup("R9", 16'h0A0A, 1, 2, 16'h00AA);
    pulse_tick(2);
    wait_notif(seen);
    chk("R8", "hit reset idle", int'(seen), 0);
    pulse_tick(1);
    wait_notif(seen);
    chk("R9", "rearmed notif", int'(seen), 1);
    chk("R9", "rearmed idx", int'(nidx), 2);
    drain;
  endtask

  task automatic t_mode_off;
    bit seen;
    cp(1, 2, 0, 0, 0);
    cp(1, 4, 0, 0, 0);
    mode = 0;
    cp(0, 2, 16'h0C0C, 16'h00CC, 2);
    pulse_tick(5);
    wait_notif(seen);
    chk("R11", "no notif in off mode", int'(seen), 0);
    mode = 1;
    wait_notif(seen);
    chk("R11", "notif after enabling", int'(seen), 1);
    chk("R11", "notif_key", int'(nkey), 16'h0C0C);
    drain;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_cp_lookup;
    t_learn_disabled;
    t_learn_next_hit;
    t_collision;
    t_cp_edit_learned;
    t_fill;
    t_aging;
    t_mode_off;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule